// File: doc/BRIEF.md
# Byte-Wide SPI Master With Register Interface

This block is an SPI controller that only acts as master and moves one byte at a time. A host reaches it through a small register bus with 8-bit data. The registers cover control, a second control byte, clock rate, status, data, a pin-level port value and pin directions. When the controller is enabled, a write to the data register starts a transfer. The byte goes out on MOSI while a byte is collected from MISO, and the received byte can then be read back from the same data register. Clock polarity, clock phase and bit order are each chosen in the control register. The SCK rate comes from a 3-bit prescaler multiplied by a power of two.

Slave select is not driven by the shifter. Software sets it through one bit of the port-data register. The controller has three status flags: byte complete, write collision and mode fault. A mode fault means that another master pulled the slave-select sense input low. Byte complete and mode fault each drive their own interrupt line. To read without sending data, the host writes a zero byte, and each finished byte then leaves one received byte in the data register.

Top module: `spi_byte_master`

## Requirements
- R1: After reset the status register (offset 0x05) and the data register (offset 0x09) read 0x00. The port-data register (offset 0x0D) reads 0x08, which holds `ss_n` high. The direction register (offset 0x10) reads 0x00. `sck`, every output enable and both interrupts are low.
- R2: Control register 1 (offset 0x00) has these bits: 7 interrupt enable, 6 enable, 4 master, 3 CPOL, 2 CPHA, 0 LSB-first. When enable is 1 and no byte is in flight, a write to the data register makes exactly 16 SCK edges. Consecutive edges are H = (P+1)·2^E clocks apart, where P is baud-register (offset 0x02) bits 6:4 and E is bits 2:0. Between bytes SCK rests at CPOL.
- R3: With LSB-first = 0 the byte leaves MSB first. With LSB-first = 1 it leaves LSB first. The received byte is put together in the same order.
- R4: With CPHA = 0, MOSI is valid at the odd edges (1, 3, … 15) and MISO is sampled there. With CPHA = 1 both happen at the even edges (2, 4, … 16). After the byte completes, reads of the data register return the received byte.
- R5: A completed byte sets status bit 7, and while bit 7 of control register 1 is 1 it drives `irq_xfer` high. The flag clears only when a status read that returned bit 7 set is followed by a data read. A data read on its own leaves the flag set.
- R6: A data write while a byte is in flight sets status bit 6 and does not change the byte being shifted. The flag clears when a status read that returned bit 6 set is followed by a data read.
- R7: While enable and master are both 1, a low level on `ss_in_n` sets status bit 4. While bit 7 of control register 1 is 1, it also drives `irq_modf` high. The flag clears when a status read that returned bit 4 set is followed by a write to control register 1. A write to control register 1 on its own leaves the flag set. While enable is 0, a low `ss_in_n` sets nothing.
- R8: Clearing enable stops a byte in flight. SCK returns to CPOL and no completion is flagged. A data write while enable is 0 produces no SCK edge and sets no flag.
- R9: `ss_n` follows port-data bit 3. `mosi_oe`, `sck_oe` and `ss_oe` follow direction bits 1, 2 and 3, so 0x0E enables all three. Control register 2 (offset 0x01), the port-data register and the direction register read back what was written.
- R10: The divider covers its full range. P = 0 with E = 0 gives an edge every clock, which is a divide ratio of 2. P = 7 with E = 7 gives an edge every 1024 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 5 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data appears on `reg_rdata` one clock later |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| miso | input | 1 | Serial data from slave |
| ss_in_n | input | 1 | Slave-select sense input used for mode-fault detection |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to slave |
| ss_n | output | 1 | Slave select, active low, driven from port-data bit 3 |
| sck_oe | output | 1 | Output enable for SCK |
| mosi_oe | output | 1 | Output enable for MOSI |
| ss_oe | output | 1 | Output enable for slave select |
| irq_xfer | output | 1 | Byte-complete interrupt |
| irq_modf | output | 1 | Mode-fault interrupt |

## Verification
The hardest case to reach is a data write that lands while a byte is still shifting. The second write must raise the collision flag and must not disturb the serial stream already under way. To get there, the bench starts a byte at a slow clock rate and writes the data register again a few clocks later. It then rebuilds the transmitted byte from MOSI at the sampling edges and checks it against the first byte. Each clear sequence is also checked out of order, for example a data read with no status read before it, to show that only the documented order clears a flag.

// File: rtl/spi_bm_pkg.sv
`timescale 1ns/1ps
package spi_bm_pkg;
  localparam int REG_AW = 5;
  localparam int REG_DW = 8;

  localparam logic [REG_AW-1:0] OFS_CTRL1 = 5'h00;
  localparam logic [REG_AW-1:0] OFS_CTRL2 = 5'h01;
  localparam logic [REG_AW-1:0] OFS_BAUD  = 5'h02;
  localparam logic [REG_AW-1:0] OFS_STAT  = 5'h05;
  localparam logic [REG_AW-1:0] OFS_DATA  = 5'h09;
  localparam logic [REG_AW-1:0] OFS_PORT  = 5'h0D;
  localparam logic [REG_AW-1:0] OFS_DIR   = 5'h10;

  // control register 1 bit positions
  localparam int C1_IRQEN = 7;
  localparam int C1_EN    = 6;
  localparam int C1_MSTR  = 4;
  localparam int C1_CPOL  = 3;
  localparam int C1_CPHA  = 2;
  localparam int C1_LSB   = 0;

  // status bit positions
  localparam int ST_DONE = 7;
  localparam int ST_COLL = 6;
  localparam int ST_MFLT = 4;

  // port-data / direction bit positions
  localparam int PD_SS   = 3;
  localparam int DR_MOSI = 1;
  localparam int DR_SCK  = 2;
  localparam int DR_SS   = 3;

  typedef struct packed {
    logic cpol;
    logic cpha;
    logic lsb;
  } wire_mode_t;
endpackage

// File: rtl/spi_bm_baud.sv
`timescale 1ns/1ps
module spi_bm_baud #(
  parameter int PRE_W = 3,
  parameter int EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PRE_W-1:0] pre,
  input  logic [EXP_W-1:0] expo,
  output logic             tick
);
  localparam int CNT_W = PRE_W + (1 << EXP_W);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] half;
  logic [CNT_W-1:0] half_m1;

  // half SCK period in system clocks: (pre+1) * 2^expo
  always_comb begin
    half    = (CNT_W'(pre) + CNT_W'(1)) << expo;
    half_m1 = half - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (cnt_q == half_m1) begin
      cnt_q <= '0;
      tick  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
      tick  <= 1'b0;
    end
  end

  // R2: an SCK step request only follows a cycle in which the divider ran
  p_tick_needs_run_r2: assert property (@(posedge clk) disable iff (rst)
    tick |-> $past(run));
endmodule

// File: rtl/spi_bm_shift.sv
`timescale 1ns/1ps
module spi_bm_shift
  import spi_bm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_byte,
  input  wire_mode_t        mode,
  input  logic              tick,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int EDGES = 2 * DATA_W;
  localparam int EC_W  = $clog2(EDGES + 1);

  logic [EC_W-1:0]   edge_q;
  logic [EC_W-1:0]   edge_nxt;
  logic [DATA_W-1:0] tx_q;
  logic [DATA_W-1:0] rx_q;
  logic [DATA_W-1:0] tx_nxt;
  logic [DATA_W-1:0] rx_nxt;
  logic              cpha_q;
  logic              lsb_q;
  logic              leading;
  logic              sample_now;
  logic              shift_now;
  logic              last_edge;

  function automatic logic lead_bit(input logic [DATA_W-1:0] v, input logic lsb_first);
    return lsb_first ? v[0] : v[DATA_W-1];
  endfunction

  always_comb begin
    edge_nxt   = edge_q + EC_W'(1);
    leading    = edge_nxt[0];
    sample_now = tick && (cpha_q ? !leading : leading);
    shift_now  = tick && (cpha_q ? (leading && edge_q != '0) : !leading);
    last_edge  = tick && (edge_nxt == EC_W'(EDGES));
    if (sample_now)
      rx_nxt = lsb_q ? {miso, rx_q[DATA_W-1:1]} : {rx_q[DATA_W-2:0], miso};
    else
      rx_nxt = rx_q;
    tx_nxt = lsb_q ? {1'b0, tx_q[DATA_W-1:1]} : {tx_q[DATA_W-2:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      edge_q  <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
      rx_byte <= '0;
      sck     <= 1'b0;
      mosi    <= 1'b0;
      cpha_q  <= 1'b0;
      lsb_q   <= 1'b0;
    end else if (hold) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      edge_q <= '0;
      sck    <= mode.cpol;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        sck <= mode.cpol;
        if (start) begin
          busy   <= 1'b1;
          edge_q <= '0;
          cpha_q <= mode.cpha;
          lsb_q  <= mode.lsb;
          tx_q   <= tx_byte;
          rx_q   <= '0;
          mosi   <= lead_bit(tx_byte, mode.lsb);
        end
      end else if (tick) begin
        sck    <= ~sck;
        rx_q   <= rx_nxt;
        edge_q <= edge_nxt;
        if (shift_now) begin
          tx_q <= tx_nxt;
          mosi <= lead_bit(tx_nxt, lsb_q);
        end
        if (last_edge) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          edge_q  <= '0;
          rx_byte <= rx_nxt;
        end
      end
    end
  end

  // R6: the register side never restarts a byte already in flight
  p_start_only_idle_r6: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);
  // R2: completion comes only after the full count of edges
  p_done_after_byte_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busy) && $past(edge_q) == EC_W'(EDGES - 1)));
  // R2: within a byte SCK moves only on a divider step
  p_sck_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && sck != $past(sck)) |-> $past(tick));
  // R8: holding the block stops the byte without completion
  p_hold_stops_r8: assert property (@(posedge clk) disable iff (rst)
    $past(hold) |-> (!busy && !done));
  // R2: idle SCK sits at the polarity level
  p_sck_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy) && !$past(start) && $stable(mode.cpol)) |-> sck == mode.cpol);
endmodule

// File: rtl/spi_bm_regs.sv
`timescale 1ns/1ps
module spi_bm_regs
  import spi_bm_pkg::*;
#(
  parameter int PRE_W       = 3,
  parameter int EXP_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_DW-1:0] bus_wdata,
  output logic [REG_DW-1:0] bus_rdata,
  input  logic              ss_in_n,
  input  logic              xfer_busy,
  input  logic              xfer_done,
  input  logic [REG_DW-1:0] rx_byte,
  output logic              enable,
  output wire_mode_t        mode,
  output logic [PRE_W-1:0]  pre,
  output logic [EXP_W-1:0]  expo,
  output logic              start,
  output logic [REG_DW-1:0] tx_byte,
  output logic              ss_n,
  output logic              mosi_oe,
  output logic              sck_oe,
  output logic              ss_oe,
  output logic              irq_xfer,
  output logic              irq_modf
);
  logic [REG_DW-1:0] ctrl1_q, ctrl2_q, baud_q, port_q, dir_q;
  logic done_q, coll_q, mflt_q;
  logic done_arm_q, coll_arm_q, mflt_arm_q;
  logic wr_ctrl1, wr_data, rd_stat, rd_data;
  logic busy_eff, mflt_set, ss_low;
  logic [SYNC_STAGES-1:0] ss_sync_q;
  logic [REG_DW-1:0] stat_val;

  always_comb begin
    wr_ctrl1 = bus_wr && bus_addr == OFS_CTRL1;
    wr_data  = bus_wr && bus_addr == OFS_DATA;
    rd_stat  = bus_rd && bus_addr == OFS_STAT;
    rd_data  = bus_rd && bus_addr == OFS_DATA;
    busy_eff = xfer_busy || start;
    enable   = ctrl1_q[C1_EN];
    mode     = '{cpol: ctrl1_q[C1_CPOL], cpha: ctrl1_q[C1_CPHA], lsb: ctrl1_q[C1_LSB]};
    pre      = baud_q[4 +: PRE_W];
    expo     = baud_q[0 +: EXP_W];
    ss_low   = !ss_sync_q[SYNC_STAGES-1];
    mflt_set = enable && ctrl1_q[C1_MSTR] && ss_low;
    stat_val = '0;
    stat_val[ST_DONE] = done_q;
    stat_val[ST_COLL] = coll_q;
    stat_val[ST_MFLT] = mflt_q;
  end

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) ss_sync_q <= rst ? 1'b1 : ss_in_n;
    end else begin : g_syncn
      always_ff @(posedge clk)
        ss_sync_q <= rst ? '1 : {ss_sync_q[SYNC_STAGES-2:0], ss_in_n};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl1_q <= '0;
      ctrl2_q <= '0;
      baud_q  <= '0;
      port_q  <= 8'h08;
      dir_q   <= '0;
      tx_byte <= '0;
      start   <= 1'b0;
    end else begin
      if (wr_ctrl1) ctrl1_q <= bus_wdata;
      if (bus_wr && bus_addr == OFS_CTRL2) ctrl2_q <= bus_wdata;
      if (bus_wr && bus_addr == OFS_BAUD)  baud_q  <= bus_wdata;
      if (bus_wr && bus_addr == OFS_PORT)  port_q  <= bus_wdata;
      if (bus_wr && bus_addr == OFS_DIR)   dir_q   <= bus_wdata;
      start <= wr_data && enable && !busy_eff;
      if (wr_data && enable && !busy_eff) tx_byte <= bus_wdata;
    end
  end

  // flag set has priority over the clearing sequence
  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0; coll_q <= 1'b0; mflt_q <= 1'b0;
      done_arm_q <= 1'b0; coll_arm_q <= 1'b0; mflt_arm_q <= 1'b0;
    end else begin
      if (xfer_done)                  done_q <= 1'b1;
      else if (rd_data && done_arm_q) done_q <= 1'b0;
      if (wr_data && busy_eff)        coll_q <= 1'b1;
      else if (rd_data && coll_arm_q) coll_q <= 1'b0;
      if (mflt_set)                    mflt_q <= 1'b1;
      else if (wr_ctrl1 && mflt_arm_q) mflt_q <= 1'b0;
      if (rd_data)                    done_arm_q <= 1'b0;
      else if (rd_stat && done_q)     done_arm_q <= 1'b1;
      if (rd_data)                    coll_arm_q <= 1'b0;
      else if (rd_stat && coll_q)     coll_arm_q <= 1'b1;
      if (wr_ctrl1)                   mflt_arm_q <= 1'b0;
      else if (rd_stat && mflt_q)     mflt_arm_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      ss_n      <= 1'b1;
      mosi_oe   <= 1'b0;
      sck_oe    <= 1'b0;
      ss_oe     <= 1'b0;
      irq_xfer  <= 1'b0;
      irq_modf  <= 1'b0;
    end else begin
      ss_n     <= port_q[PD_SS];
      mosi_oe  <= dir_q[DR_MOSI];
      sck_oe   <= dir_q[DR_SCK];
      ss_oe    <= dir_q[DR_SS];
      irq_xfer <= ctrl1_q[C1_IRQEN] && done_q;
      irq_modf <= ctrl1_q[C1_IRQEN] && mflt_q;
      if (bus_rd) begin
        case (bus_addr)
          OFS_CTRL1: bus_rdata <= ctrl1_q;
          OFS_CTRL2: bus_rdata <= ctrl2_q;
          OFS_BAUD:  bus_rdata <= baud_q;
          OFS_STAT:  bus_rdata <= stat_val;
          OFS_DATA:  bus_rdata <= rx_byte;
          OFS_PORT:  bus_rdata <= port_q;
          OFS_DIR:   bus_rdata <= dir_q;
          default:   bus_rdata <= '0;
        endcase
      end
    end
  end

  // R5: the shifter's completion pulse lands in the status flag
  p_done_sets_flag_r5: assert property (@(posedge clk) disable iff (rst)
    xfer_done |=> done_q);
  // R5: no access other than a data read drops the completion flag
  p_done_holds_r5: assert property (@(posedge clk) disable iff (rst)
    (done_q && !rd_data) |=> done_q);
  // R6: the collision flag survives until a data read
  p_coll_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (coll_q && !rd_data) |=> coll_q);
  // R7: only a control-1 write may drop the mode-fault flag
  p_mflt_holds_r7: assert property (@(posedge clk) disable iff (rst)
    (mflt_q && !wr_ctrl1) |=> mflt_q);
endmodule

// File: rtl/spi_byte_master.sv
`timescale 1ns/1ps
module spi_byte_master
  import spi_bm_pkg::*;
#(
  parameter int PRE_W       = 3,
  parameter int EXP_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [4:0]  reg_addr,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        miso,
  input  logic        ss_in_n,
  output logic        sck,
  output logic        mosi,
  output logic        ss_n,
  output logic        sck_oe,
  output logic        mosi_oe,
  output logic        ss_oe,
  output logic        irq_xfer,
  output logic        irq_modf
);
  wire_mode_t        mode;
  logic              enable, start, busy, done, tick;
  logic [PRE_W-1:0]  pre;
  logic [EXP_W-1:0]  expo;
  logic [REG_DW-1:0] tx_byte, rx_byte;

  spi_bm_regs #(.PRE_W(PRE_W), .EXP_W(EXP_W), .SYNC_STAGES(SYNC_STAGES)) u_regs (
    .clk(clk), .rst(rst),
    .bus_addr(reg_addr), .bus_wr(reg_wr), .bus_rd(reg_rd),
    .bus_wdata(reg_wdata), .bus_rdata(reg_rdata),
    .ss_in_n(ss_in_n), .xfer_busy(busy), .xfer_done(done), .rx_byte(rx_byte),
    .enable(enable), .mode(mode), .pre(pre), .expo(expo),
    .start(start), .tx_byte(tx_byte),
    .ss_n(ss_n), .mosi_oe(mosi_oe), .sck_oe(sck_oe), .ss_oe(ss_oe),
    .irq_xfer(irq_xfer), .irq_modf(irq_modf)
  );

  spi_bm_baud #(.PRE_W(PRE_W), .EXP_W(EXP_W)) u_baud (
    .clk(clk), .rst(rst), .run(busy && enable),
    .pre(pre), .expo(expo), .tick(tick)
  );

  spi_bm_shift #(.DATA_W(REG_DW)) u_shift (
    .clk(clk), .rst(rst), .hold(!enable), .start(start),
    .tx_byte(tx_byte), .mode(mode), .tick(tick), .miso(miso),
    .sck(sck), .mosi(mosi), .busy(busy), .done(done), .rx_byte(rx_byte)
  );
endmodule

// File: tb/test_spi_byte_master.sv
`timescale 1ns/1ps
module test_spi_byte_master;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic miso, ss_in_n = 1'b1;
  logic sck, mosi, ss_n, sck_oe, mosi_oe, ss_oe, irq_xfer, irq_modf;

  always #2.5 clk = ~clk;

  // slave model: echoes the inverted MOSI, so the received byte is ~tx
  assign miso = ~mosi;

  spi_byte_master i_spi_byte_master (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .miso(miso), .ss_in_n(ss_in_n),
    .sck(sck), .mosi(mosi), .ss_n(ss_n), .sck_oe(sck_oe), .mosi_oe(mosi_oe),
    .ss_oe(ss_oe), .irq_xfer(irq_xfer), .irq_modf(irq_modf)
  );

  localparam logic [4:0] A_C1 = 5'h00, A_C2 = 5'h01, A_BD = 5'h02, A_ST = 5'h05,
                         A_DT = 5'h09, A_PD = 5'h0D, A_DR = 5'h10;

  // {mode bits of control 1, baud, tx byte}
  localparam logic [23:0] VEC [0:7] = '{
    24'h00_00_A5, 24'h04_01_3C, 24'h08_10_81, 24'h0C_21_5A,
    24'h01_11_C3, 24'h05_02_01, 24'h09_30_80, 24'h0D_12_96 };

  int nchk = 0, nfail = 0;
  bit finished = 0;

  // wire monitor
  int cyc = 0, edges = 0, gap_err = 0, last_cyc = 0, nbits = 0, exp_half = 1;
  logic mon_cpha = 1'b0;
  logic sck_prev = 1'b0;
  logic [7:0] wire_seq = '0;

  always @(negedge clk) begin
    cyc++;
    if (sck !== sck_prev) begin
      edges++;
      if (edges > 1 && (cyc - last_cyc) != exp_half) gap_err++;
      last_cyc = cyc;
      if ((mon_cpha ? (edges % 2 == 0) : (edges % 2 == 1)) && nbits < 8) begin
        wire_seq = {wire_seq[6:0], mosi};
        nbits++;
      end
    end
    sck_prev = sck;
  end

  task automatic mon_clear(input logic cpha, input int half);
    mon_cpha = cpha; exp_half = half;
    edges = 0; gap_err = 0; nbits = 0; wire_seq = '0;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic poll_done(output logic ok);
    logic [7:0] s;
    ok = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      rd(A_ST, s);
      if (s[7]) begin ok = 1'b1; break; end
    end
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
  endfunction

  function automatic int half_of(input logic [7:0] b);
    return (int'(b[6:4]) + 1) << b[2:0];
  endfunction

  task automatic run_byte(input logic [7:0] m, input logic [7:0] b, input logic [7:0] tx,
                          input string rq);
    logic ok; logic [7:0] v;
    wr(A_C1, 8'h50 | m);
    wr(A_BD, b);
    idle(3);
    mon_clear(m[2], half_of(b));
    wr(A_DT, tx);
    poll_done(ok);
    chk(ok, {rq, " R5 completion flag"}, ok, 1);
    idle(2);
    chk(edges == 16, "R2 edge count", edges, 16);
    chk(gap_err == 0, {rq, " edge spacing"}, gap_err, 0);
    chk(sck == m[3], "R2 idle level", sck, m[3]);
    chk(wire_seq == (m[0] ? rev8(tx) : tx), "R3 R4 wire order", wire_seq, m[0] ? rev8(tx) : tx);
    rd(A_DT, v);
    chk(v == ~tx, "R4 received byte", v, ~tx);
    rd(A_ST, v);
    chk(v == 8'h00, "R5 cleared after status+data", v, 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: got 0x0 expected 0x1");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v;
    logic ok;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle(2);

    // R1 reset state
    rd(A_ST, v); chk(v == 8'h00, "R1 status", v, 0);
    rd(A_DT, v); chk(v == 8'h00, "R1 data", v, 0);
    rd(A_PD, v); chk(v == 8'h08, "R1 port", v, 8'h08);
    rd(A_DR, v); chk(v == 8'h00, "R1 dir", v, 0);
    chk(ss_n == 1'b1, "R1 ss_n", ss_n, 1);
    chk({sck, sck_oe, mosi_oe, ss_oe, irq_xfer, irq_modf} == 6'b0, "R1 pins",
        {sck, sck_oe, mosi_oe, ss_oe, irq_xfer, irq_modf}, 0);

    // R9 pin control and readback
    wr(A_DR, 8'h0E); wr(A_PD, 8'h00); wr(A_C2, 8'h5A); idle(2);
    chk({mosi_oe, sck_oe, ss_oe} == 3'b111, "R9 output enables", {mosi_oe, sck_oe, ss_oe}, 7);
    chk(ss_n == 1'b0, "R9 ss_n low", ss_n, 0);
    rd(A_C2, v); chk(v == 8'h5A, "R9 ctrl2 readback", v, 8'h5A);
    wr(A_DR, 8'h04); idle(2);
    chk({mosi_oe, sck_oe, ss_oe} == 3'b010, "R9 sck only", {mosi_oe, sck_oe, ss_oe}, 2);
    wr(A_DR, 8'h0E);

    // table of mode / rate / byte vectors
    for (int i = 0; i < 8; i++)
      run_byte({5'b0, VEC[i][18:16]}, VEC[i][15:8], VEC[i][7:0], i == 0 ? "R10 min divider" : "R2");

    // R10 largest divider
    run_byte(8'h00, 8'h77, 8'h69, "R10 max divider");

    // R5 interrupt and clear ordering
    wr(A_C1, 8'hD0); wr(A_BD, 8'h01); idle(2);
    mon_clear(1'b0, 2);
    wr(A_DT, 8'h42);
    idle(16 * 2 + 10);
    chk(irq_xfer == 1'b1, "R5 irq_xfer raised", irq_xfer, 1);
    rd(A_DT, v);
    rd(A_ST, v); chk(v == 8'h80, "R5 data read alone keeps flag", v, 8'h80);
    rd(A_DT, v); chk(v == 8'hBD, "R5 received byte", v, 8'hBD);
    idle(3);
    chk(irq_xfer == 1'b0, "R5 irq_xfer cleared", irq_xfer, 0);
    rd(A_ST, v); chk(v == 8'h00, "R5 status after clear", v, 0);

    // R6 collision during a slow byte
    wr(A_C1, 8'h50); wr(A_BD, 8'h02); idle(2);
    mon_clear(1'b0, 4);
    wr(A_DT, 8'hC6);
    idle(10);
    wr(A_DT, 8'hFF);
    rd(A_ST, v); chk(v[6] == 1'b1, "R6 collision flag", v, 8'h40);
    poll_done(ok);
    idle(2);
    chk(edges == 16, "R6 edges unchanged", edges, 16);
    chk(wire_seq == 8'hC6, "R6 first byte intact", wire_seq, 8'hC6);
    rd(A_ST, v); chk(v == 8'hC0, "R6 both flags", v, 8'hC0);
    rd(A_DT, v); chk(v == 8'h39, "R6 received byte", v, 8'h39);
    rd(A_ST, v); chk(v == 8'h00, "R6 flags cleared", v, 0);

    // R7 mode fault
    wr(A_C1, 8'h00);
    ss_in_n = 1'b0; idle(8); ss_in_n = 1'b1; idle(6);
    rd(A_ST, v); chk(v == 8'h00, "R7 no fault when disabled", v, 0);
    wr(A_C1, 8'hD0);
    ss_in_n = 1'b0; idle(8); ss_in_n = 1'b1; idle(6);
    chk(irq_modf == 1'b1, "R7 irq_modf raised", irq_modf, 1);
    wr(A_C1, 8'hD0); idle(3);
    chk(irq_modf == 1'b1, "R7 ctrl write alone keeps flag", irq_modf, 1);
    rd(A_ST, v); chk(v == 8'h10, "R7 status fault bit", v, 8'h10);
    wr(A_C1, 8'hD0); idle(3);
    chk(irq_modf == 1'b0, "R7 irq_modf cleared", irq_modf, 0);
    rd(A_ST, v); chk(v == 8'h00, "R7 status cleared", v, 0);

    // R8 abort by clearing enable, and writes while disabled
    wr(A_C1, 8'h58); wr(A_BD, 8'h02); idle(2);
    wr(A_DT, 8'h33);
    idle(20);
    wr(A_C1, 8'h18); idle(3);
    chk(sck == 1'b1, "R8 sck back to cpol", sck, 1);
    idle(100);
    rd(A_ST, v); chk(v == 8'h00, "R8 no completion after abort", v, 0);
    mon_clear(1'b0, 4);
    wr(A_DT, 8'hAA);
    idle(100);
    chk(edges == 0, "R8 no edges while disabled", edges, 0);
    rd(A_ST, v); chk(v == 8'h00, "R8 no flag while disabled", v, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule